// File: doc/BRIEF.md
# Circular FIFO Pointer Manager

This block keeps the pointer state of a set of ring buffers that live in memory and turns each FIFO transfer request from a DSP into a series of address-contiguous chunk requests. Every ring has three registers: a start address (base), a limit address (end, exclusive) and a current position (cur). The registers are split into an input bank and an output bank, and the transfer direction picks the bank. The data itself never passes through the block. It hands out addresses and lengths only, and a downstream address-translation stage moves the bytes.

When a request is accepted, the block takes a copy of the selected ring's registers. It then repairs a current position that lies outside the ring. Next it cuts the requested byte count into chunks that never cross the ring limit, and it restarts at base each time the limit is reached. At the end it writes the final position back to the ring's current register and reports completion. A single-cycle completion with an error flag rejects a ring that does not exist or has no size.

Top module: `cpm_ring_mgr`

## Requirements
- R1: Register access uses a word address {bank, index, field}. The bank is the top bit (0 = input, 1 = output). The index sits above the 2-bit field, so successive rings are 4 words (16 bytes) apart. The field codes are 0 = base, 1 = end and 2 = cur. Field 3 reads as zero and ignores writes. An index at or above the bank's ring count reads as zero and ignores writes. All registers reset to zero.
- R2: `req_ready` is high only while no transfer is in progress. A request is accepted on a rising edge with `req_valid` and `req_ready` both high.
- R3: The block rejects a request when the index is at or above the bank's ring count, or when end is not above base. It raises `done_valid` with `done_err` = 1, issues no chunk, and leaves the current register unchanged.
- R4: When cur is at or above end, the block replaces it with cur modulo (end - base) before any chunk is issued.
- R5: After R4, a cur below base is raised to base.
- R6: Each chunk starts at the current position. Its length is the smaller of (end - current) and the bytes still to move. A chunk is never empty and always lies inside [base, end].
- R7: After each chunk the position advances by the chunk length. On reaching end it becomes base, so the next chunk starts at base.
- R8: A chunk keeps `chk_valid`, `chk_addr` and `chk_len` steady until `chk_ready` is seen. The next chunk appears only after that handshake.
- R9: Completion is a one-cycle `done_valid` pulse. On success `done_cur` gives the final position, and this value is written to the ring's cur register. A zero-length request issues no chunk and writes back the repaired position.
- R10: `chk_dir` carries the request direction. `chk_zero` (send silence) is 1 only for output ring 0 when the request asked for silence.
- R11: Without a fold, `chk_valid` is first high after the first rising edge following the accepting edge. With a fold (R4) it is first high after edge AW+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | IW+3 | Register word address {bank, index, field} |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational from reg_addr) |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_dir | input | 1 | 0 = input ring, 1 = output ring |
| req_idx | input | IW | Ring index within the bank |
| req_len | input | LW | Transfer length in bytes |
| req_sink | input | 1 | Ask for silence on output ring 0 |
| chk_valid | output | 1 | Chunk request valid |
| chk_ready | input | 1 | Downstream accepts the chunk |
| chk_addr | output | AW | Chunk start address |
| chk_len | output | LW | Chunk length in bytes |
| chk_dir | output | 1 | Chunk direction |
| chk_zero | output | 1 | Downstream sends zeros instead of data |
| done_valid | output | 1 | Transfer complete pulse |
| done_err | output | 1 | Request rejected |
| done_cur | output | AW | Final current position |

## Verification
The bench counts rising edges from the edge that accepts a request. Without a fold the first chunk must be present one edge later. With a fold it must be present AW+2 edges later, and the bench reads that edge count as a check of R11. Each chunk is sampled on the falling edge before the edge where `chk_ready` completes its handshake. Completion is sampled on the falling edge after the final handshake. The written-back pointer is read from the register port only after that pulse has gone.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
package cpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FOLD,
    ST_ISSUE,
    ST_DONE
  } cpm_state_e;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_END  = 2'd1,
    FLD_CUR  = 2'd2,
    FLD_RSVD = 2'd3
  } cpm_fld_e;

endpackage

// File: rtl/cpm_regbank.sv
`timescale 1ns/1ps
module cpm_regbank
  import cpm_pkg::*;
#(
  parameter int N  = 2,
  parameter int IW = 3,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_fld,
  input  logic [AW-1:0] wr_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [AW-1:0] wb_data,
  input  logic [IW-1:0] ra_idx,
  output logic [AW-1:0] ra_base,
  output logic [AW-1:0] ra_end,
  output logic [AW-1:0] ra_cur,
  input  logic [IW-1:0] rb_idx,
  output logic          rb_hit,
  output logic [AW-1:0] rb_base,
  output logic [AW-1:0] rb_end,
  output logic [AW-1:0] rb_cur
);

  logic [AW-1:0] base_q [N];
  logic [AW-1:0] end_q  [N];
  logic [AW-1:0] cur_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel_w, sel_b;
    logic base_en, end_en, cur_en;
    logic [AW-1:0] cur_d;

    always_comb begin
      sel_w   = wr_en && (wr_idx == IW'(g));
      sel_b   = wb_en && (wb_idx == IW'(g));
      base_en = sel_w && (wr_fld == FLD_BASE);
      end_en  = sel_w && (wr_fld == FLD_END);
      cur_en  = sel_b || (sel_w && (wr_fld == FLD_CUR));
      // the sequencer's write-back wins over a same-cycle software write
      cur_d   = sel_b ? wb_data : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        end_q[g]  <= '0;
        cur_q[g]  <= '0;
      end else begin
        if (base_en) base_q[g] <= wr_data;
        if (end_en)  end_q[g]  <= wr_data;
        if (cur_en)  cur_q[g]  <= cur_d;
      end
    end
  end

  always_comb begin
    ra_base = '0;
    ra_end  = '0;
    ra_cur  = '0;
    rb_hit  = 1'b0;
    rb_base = '0;
    rb_end  = '0;
    rb_cur  = '0;
    for (int i = 0; i < N; i++) begin
      if (ra_idx == IW'(i)) begin
        ra_base = base_q[i];
        ra_end  = end_q[i];
        ra_cur  = cur_q[i];
      end
      if (rb_idx == IW'(i)) begin
        rb_hit  = 1'b1;
        rb_base = base_q[i];
        rb_end  = end_q[i];
        rb_cur  = cur_q[i];
      end
    end
  end

  // R9: only rings that exist are ever written back
  a_r9_wb_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (int'(wb_idx) < N));

endmodule

// File: rtl/cpm_mod.sv
`timescale 1ns/1ps
module cpm_mod #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] dvd,
  input  logic [AW-1:0] dvs,
  output logic          done,
  output logic [AW-1:0] rem
);

  localparam int CW = $clog2(AW + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] acc_q, acc_n;
  logic [AW-1:0] sh_q, sh_n;
  logic [AW-1:0] dvs_q, dvs_n;
  logic          done_q, done_n;
  logic [AW:0]   trial, diff;

  always_comb begin
    trial  = {acc_q, sh_q[AW-1]};
    diff   = trial - {1'b0, dvs_q};
    cnt_n  = cnt_q;
    acc_n  = acc_q;
    sh_n   = sh_q;
    dvs_n  = dvs_q;
    done_n = 1'b0;
    if (start) begin
      cnt_n = CW'(AW);
      acc_n = '0;
      sh_n  = dvd;
      dvs_n = dvs;
    end else if (cnt_q != '0) begin
      // restoring step: keep the difference unless it borrowed
      acc_n  = diff[AW] ? trial[AW-1:0] : diff[AW-1:0];
      sh_n   = {sh_q[AW-2:0], 1'b0};
      cnt_n  = cnt_q - 1'b1;
      done_n = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      sh_q   <= '0;
      dvs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
      sh_q   <= sh_n;
      dvs_q  <= dvs_n;
      done_q <= done_n;
    end
  end

  assign done = done_q;
  assign rem  = acc_q;

  // R4: a finished fold is strictly inside the ring span
  a_r4_rem_lt_div: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (acc_q < dvs_q));

endmodule

// File: rtl/cpm_seq.sv
`timescale 1ns/1ps
module cpm_seq
  import cpm_pkg::*;
#(
  parameter int IW = 3,
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_dir,
  input  logic [IW-1:0] req_idx,
  input  logic [LW-1:0] req_len,
  input  logic          req_sink,
  input  logic          sn_hit,
  input  logic [AW-1:0] sn_base,
  input  logic [AW-1:0] sn_end,
  input  logic [AW-1:0] sn_cur,
  output logic          mod_start,
  output logic [AW-1:0] mod_dvd,
  output logic [AW-1:0] mod_dvs,
  input  logic          mod_done,
  input  logic [AW-1:0] mod_rem,
  output logic          chk_valid,
  input  logic          chk_ready,
  output logic [AW-1:0] chk_addr,
  output logic [LW-1:0] chk_len,
  output logic          chk_dir,
  output logic          chk_zero,
  output logic          done_valid,
  output logic          done_err,
  output logic [AW-1:0] done_cur,
  output logic          wb_en,
  output logic          wb_dir,
  output logic [IW-1:0] wb_idx,
  output logic [AW-1:0] wb_cur
);

  localparam int MW = (AW > LW) ? AW : LW;
  localparam int SW = MW + 1;

  cpm_state_e    st_q, st_n;
  logic          dir_q, dir_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          sink_q, sink_n;
  logic          hit_q, hit_n;
  logic          err_q, err_n;
  logic [AW-1:0] base_q, base_n;
  logic [AW-1:0] end_q, end_n;
  logic [AW-1:0] cur_q, cur_n;
  logic [LW-1:0] left_q, left_n;

  logic [MW-1:0] room_m, left_m, take_m;
  logic [AW-1:0] step_cur;

  function automatic logic [AW-1:0] lift(input logic [AW-1:0] v, input logic [AW-1:0] b);
    return (v < b) ? b : v;
  endfunction

  always_comb begin
    room_m   = MW'(end_q - cur_q);
    left_m   = MW'(left_q);
    take_m   = (left_m < room_m) ? left_m : room_m;
    step_cur = cur_q + AW'(take_m);
  end

  always_comb begin
    st_n      = st_q;
    dir_n     = dir_q;
    idx_n     = idx_q;
    sink_n    = sink_q;
    hit_n     = hit_q;
    err_n     = err_q;
    base_n    = base_q;
    end_n     = end_q;
    cur_n     = cur_q;
    left_n    = left_q;
    mod_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_n   = ST_CHECK;
          dir_n  = req_dir;
          idx_n  = req_idx;
          sink_n = req_sink;
          hit_n  = sn_hit;
          base_n = sn_base;
          end_n  = sn_end;
          cur_n  = sn_cur;
          left_n = req_len;
          err_n  = 1'b0;
        end
      end
      ST_CHECK: begin
        if (!hit_q || (end_q <= base_q)) begin
          err_n = 1'b1;
          st_n  = ST_DONE;
        end else if (cur_q >= end_q) begin
          mod_start = 1'b1;
          st_n      = ST_FOLD;
        end else begin
          cur_n = lift(cur_q, base_q);
          st_n  = (left_q == '0) ? ST_DONE : ST_ISSUE;
        end
      end
      ST_FOLD: begin
        if (mod_done) begin
          cur_n = lift(mod_rem, base_q);
          st_n  = (left_q == '0) ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (chk_ready) begin
          cur_n  = (step_cur == end_q) ? base_q : step_cur;
          left_n = left_q - chk_len;
          if (left_q == chk_len) st_n = ST_DONE;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dir_q  <= 1'b0;
      idx_q  <= '0;
      sink_q <= 1'b0;
      hit_q  <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      end_q  <= '0;
      cur_q  <= '0;
      left_q <= '0;
    end else begin
      st_q   <= st_n;
      dir_q  <= dir_n;
      idx_q  <= idx_n;
      sink_q <= sink_n;
      hit_q  <= hit_n;
      err_q  <= err_n;
      base_q <= base_n;
      end_q  <= end_n;
      cur_q  <= cur_n;
      left_q <= left_n;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign chk_valid  = (st_q == ST_ISSUE);
  assign chk_addr   = cur_q;
  assign chk_len    = LW'(take_m);
  assign chk_dir    = dir_q;
  assign chk_zero   = dir_q && (idx_q == '0) && sink_q;
  assign done_valid = (st_q == ST_DONE);
  assign done_err   = err_q;
  assign done_cur   = cur_q;
  assign wb_en      = done_valid && !err_q;
  assign wb_dir     = dir_q;
  assign wb_idx     = idx_q;
  assign wb_cur     = cur_q;
  assign mod_dvd    = cur_q;
  assign mod_dvs    = end_q - base_q;

  // R6: every chunk is non-empty and lies inside the ring
  a_r6_chunk_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> (chk_len != '0) && (chk_addr >= base_q) &&
                  ((SW'(chk_addr) + SW'(chk_len)) <= SW'(end_q)));

  // R8: a stalled chunk holds still
  a_r8_hold_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ready) |=> chk_valid && $stable(chk_addr) && $stable(chk_len));

  // R2: no new request is taken while chunks are outstanding
  a_r2_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> !req_ready);

  // R9: completion is a single-cycle pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  // R7: the position after a handshake never sits at the ring end
  a_r7_wrap_base: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_ready) |=> (chk_addr != end_q));

endmodule

// File: rtl/cpm_ring_mgr.sv
`timescale 1ns/1ps
module cpm_ring_mgr
  import cpm_pkg::*;
#(
  parameter int NUM_IN  = 2,
  parameter int NUM_OUT = 4,
  parameter int IW      = 3,
  parameter int AW      = 16,
  parameter int LW      = 16,
  localparam int RAW    = IW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [AW-1:0]  reg_wdata,
  output logic [AW-1:0]  reg_rdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_dir,
  input  logic [IW-1:0]  req_idx,
  input  logic [LW-1:0]  req_len,
  input  logic           req_sink,
  output logic           chk_valid,
  input  logic           chk_ready,
  output logic [AW-1:0]  chk_addr,
  output logic [LW-1:0]  chk_len,
  output logic           chk_dir,
  output logic           chk_zero,
  output logic           done_valid,
  output logic           done_err,
  output logic [AW-1:0]  done_cur
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic          a_bank;
  logic [IW-1:0] a_idx;
  logic [1:0]    a_fld;
  assign a_bank = reg_addr[RAW-1];
  assign a_idx  = reg_addr[RAW-2:2];
  assign a_fld  = reg_addr[1:0];

  logic [AW-1:0] ra_base [2];
  logic [AW-1:0] ra_end  [2];
  logic [AW-1:0] ra_cur  [2];
  logic          rb_hit  [2];
  logic [AW-1:0] rb_base [2];
  logic [AW-1:0] rb_end  [2];
  logic [AW-1:0] rb_cur  [2];

  logic          wb_en, wb_dir;
  logic [IW-1:0] wb_idx;
  logic [AW-1:0] wb_cur;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam int NE = (g == 0) ? NUM_IN : NUM_OUT;
    cpm_regbank #(.N(NE), .IW(IW), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (srst_n),
      .wr_en   (reg_we && (a_bank == 1'(g))),
      .wr_idx  (a_idx),
      .wr_fld  (a_fld),
      .wr_data (reg_wdata),
      .wb_en   (wb_en && (wb_dir == 1'(g))),
      .wb_idx  (wb_idx),
      .wb_data (wb_cur),
      .ra_idx  (a_idx),
      .ra_base (ra_base[g]),
      .ra_end  (ra_end[g]),
      .ra_cur  (ra_cur[g]),
      .rb_idx  (req_idx),
      .rb_hit  (rb_hit[g]),
      .rb_base (rb_base[g]),
      .rb_end  (rb_end[g]),
      .rb_cur  (rb_cur[g])
    );
  end

  always_comb begin
    unique case (a_fld)
      FLD_BASE: reg_rdata = ra_base[a_bank];
      FLD_END:  reg_rdata = ra_end[a_bank];
      FLD_CUR:  reg_rdata = ra_cur[a_bank];
      default:  reg_rdata = '0;
    endcase
  end

  logic          mod_start, mod_done;
  logic [AW-1:0] mod_dvd, mod_dvs, mod_rem;

  cpm_mod #(.AW(AW)) u_mod (
    .clk   (clk),
    .rst_n (srst_n),
    .start (mod_start),
    .dvd   (mod_dvd),
    .dvs   (mod_dvs),
    .done  (mod_done),
    .rem   (mod_rem)
  );

  cpm_seq #(.IW(IW), .AW(AW), .LW(LW)) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_dir    (req_dir),
    .req_idx    (req_idx),
    .req_len    (req_len),
    .req_sink   (req_sink),
    .sn_hit     (rb_hit[req_dir]),
    .sn_base    (rb_base[req_dir]),
    .sn_end     (rb_end[req_dir]),
    .sn_cur     (rb_cur[req_dir]),
    .mod_start  (mod_start),
    .mod_dvd    (mod_dvd),
    .mod_dvs    (mod_dvs),
    .mod_done   (mod_done),
    .mod_rem    (mod_rem),
    .chk_valid  (chk_valid),
    .chk_ready  (chk_ready),
    .chk_addr   (chk_addr),
    .chk_len    (chk_len),
    .chk_dir    (chk_dir),
    .chk_zero   (chk_zero),
    .done_valid (done_valid),
    .done_err   (done_err),
    .done_cur   (done_cur),
    .wb_en      (wb_en),
    .wb_dir     (wb_dir),
    .wb_idx     (wb_idx),
    .wb_cur     (wb_cur)
  );

  // R10: silence is only ever asked for on output ring 0
  a_r10_zero_out0: assert property (@(posedge clk) disable iff (!srst_n)
    (chk_valid && chk_zero) |-> chk_dir);

endmodule

// File: tb/tb_cpm_ring_mgr.sv
`timescale 1ns/1ps
module tb_cpm_ring_mgr;
  localparam int IW  = 3;
  localparam int AW  = 16;
  localparam int LW  = 16;
  localparam int RAW = IW + 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_we = 1'b0;
  logic [RAW-1:0] reg_addr = '0;
  logic [AW-1:0]  reg_wdata = '0;
  logic [AW-1:0]  reg_rdata;
  logic           req_valid = 1'b0;
  logic           req_ready;
  logic           req_dir = 1'b0;
  logic [IW-1:0]  req_idx = '0;
  logic [LW-1:0]  req_len = '0;
  logic           req_sink = 1'b0;
  logic           chk_valid;
  logic           chk_ready = 1'b0;
  logic [AW-1:0]  chk_addr;
  logic [LW-1:0]  chk_len;
  logic           chk_dir, chk_zero;
  logic           done_valid, done_err;
  logic [AW-1:0]  done_cur;

  cpm_ring_mgr #(.NUM_IN(2), .NUM_OUT(4), .IW(IW), .AW(AW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_dir(req_dir), .req_idx(req_idx),
    .req_len(req_len), .req_sink(req_sink), .chk_valid(chk_valid),
    .chk_ready(chk_ready), .chk_addr(chk_addr), .chk_len(chk_len),
    .chk_dir(chk_dir), .chk_zero(chk_zero), .done_valid(done_valid),
    .done_err(done_err), .done_cur(done_cur)
  );

  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  logic [AW-1:0] ca [16];
  logic [LW-1:0] cl [16];
  logic          cz [16];
  logic          cd [16];
  int            n_chk, lat, stab_bad;
  logic          got_done, d_err, busy_seen;
  logic [AW-1:0] d_cur;

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [RAW-1:0] ra(input logic b, input int ix, input int f);
    return {b, IW'(ix), 2'(f)};
  endfunction

  task automatic wr(input logic b, input int ix, input int f, input int v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ra(b, ix, f); reg_wdata = AW'(v);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic b, input int ix, input int f, output logic [AW-1:0] v);
    @(negedge clk);
    reg_addr = ra(b, ix, f);
    #1 v = reg_rdata;
  endtask

  task automatic set_ring(input logic b, input int ix, input int bs, input int en, input int cu);
    wr(b, ix, 0, bs);
    wr(b, ix, 1, en);
    wr(b, ix, 2, cu);
  endtask

  task automatic run_req(input logic d, input int ix, input int ln, input logic snk, input int stall);
    int cyc, hold;
    logic pv;
    logic [AW-1:0] pa;
    logic [LW-1:0] pl;
    n_chk = 0; got_done = 1'b0; lat = -1; stab_bad = 0; busy_seen = 1'b0;
    hold = stall; pv = 1'b0; pa = '0; pl = '0;
    @(negedge clk);
    req_valid = 1'b1; req_dir = d; req_idx = IW'(ix); req_len = LW'(ln); req_sink = snk;
    chk_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!got_done && cyc < 2000) begin
      if (chk_valid) begin
        if (lat < 0) begin
          lat = cyc - 1;
          busy_seen = !req_ready;
        end
        if (pv && ((chk_addr !== pa) || (chk_len !== pl))) stab_bad++;
        if (hold > 0) begin
          chk_ready = 1'b0; hold--; pv = 1'b1; pa = chk_addr; pl = chk_len;
        end else begin
          chk_ready = 1'b1; pv = 1'b0;
          if (n_chk < 16) begin
            ca[n_chk] = chk_addr; cl[n_chk] = chk_len;
            cz[n_chk] = chk_zero; cd[n_chk] = chk_dir;
          end
          n_chk++;
        end
      end else begin
        chk_ready = 1'b0;
      end
      if (done_valid) begin
        got_done = 1'b1; d_err = done_err; d_cur = done_cur;
      end
      @(negedge clk);
      cyc++;
    end
    chk_ready = 1'b0;
    check("R9 completion seen", 32'(got_done), 32'd1);
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    check("R2 ready after reset", 32'(req_ready), 32'd1);
    check("R8 no chunk after reset", 32'(chk_valid), 32'd0);
    check("R9 no done after reset", 32'(done_valid), 32'd0);
    rd(1'b1, 3, 2, v);
    check("R1 reset cur out3", 32'(v), 32'h0);
    rd(1'b0, 0, 1, v);
    check("R1 reset end in0", 32'(v), 32'h0);
  endtask

  task automatic t_regmap();
    logic [AW-1:0] v;
    set_ring(1'b0, 1, 'h111, 'h222, 'h333);
    rd(1'b0, 1, 0, v); check("R1 in1 base", 32'(v), 32'h111);
    rd(1'b0, 1, 1, v); check("R1 in1 end", 32'(v), 32'h222);
    rd(1'b0, 1, 2, v); check("R1 in1 cur", 32'(v), 32'h333);
    wr(1'b0, 1, 3, 'h777);
    rd(1'b0, 1, 3, v); check("R1 reserved field", 32'(v), 32'h0);
    rd(1'b1, 1, 0, v); check("R1 bank separation", 32'(v), 32'h0);
    wr(1'b0, 2, 0, 'h55);
    rd(1'b0, 2, 0, v); check("R1 absent ring", 32'(v), 32'h0);
  endtask

  task automatic t_single();
    logic [AW-1:0] v;
    set_ring(1'b1, 1, 'h1000, 'h1100, 'h1010);
    run_req(1'b1, 1, 'h40, 1'b0, 0);
    check("R6 single count", 32'(n_chk), 32'd1);
    check("R6 single addr", 32'(ca[0]), 32'h1010);
    check("R6 single len", 32'(cl[0]), 32'h40);
    check("R10 single dir", 32'(cd[0]), 32'd1);
    check("R11 latency no fold", 32'(lat), 32'd1);
    check("R2 busy while issuing", 32'(busy_seen), 32'd1);
    check("R9 single done_cur", 32'(d_cur), 32'h1050);
    check("R9 single err", 32'(d_err), 32'd0);
    rd(1'b1, 1, 2, v); check("R9 single write-back", 32'(v), 32'h1050);
  endtask

  task automatic t_wrap();
    logic [AW-1:0] v;
    set_ring(1'b0, 0, 'h100, 'h200, 'h1c0);
    run_req(1'b0, 0, 'h90, 1'b0, 0);
    check("R7 wrap count", 32'(n_chk), 32'd2);
    check("R6 wrap c0 addr", 32'(ca[0]), 32'h1c0);
    check("R6 wrap c0 len", 32'(cl[0]), 32'h40);
    check("R7 wrap c1 addr", 32'(ca[1]), 32'h100);
    check("R7 wrap c1 len", 32'(cl[1]), 32'h50);
    check("R7 wrap done_cur", 32'(d_cur), 32'h150);
    wr(1'b0, 0, 2, 'h1c0);
    run_req(1'b0, 0, 'h40, 1'b0, 0);
    check("R7 exact end count", 32'(n_chk), 32'd1);
    check("R7 exact end cur", 32'(d_cur), 32'h100);
    rd(1'b0, 0, 2, v); check("R7 exact end write-back", 32'(v), 32'h100);
  endtask

  task automatic t_multi();
    set_ring(1'b0, 1, 'h100, 'h140, 'h120);
    run_req(1'b0, 1, 'ha0, 1'b0, 0);
    check("R7 multi count", 32'(n_chk), 32'd3);
    check("R6 multi c0", {ca[0], cl[0]}, {16'h120, 16'h20});
    check("R7 multi c1", {ca[1], cl[1]}, {16'h100, 16'h40});
    check("R7 multi c2", {ca[2], cl[2]}, {16'h100, 16'h40});
    check("R7 multi done_cur", 32'(d_cur), 32'h100);
  endtask

  task automatic t_lift();
    set_ring(1'b1, 2, 'h100, 'h200, 'h10);
    run_req(1'b1, 2, 'h20, 1'b0, 0);
    check("R5 lifted addr", 32'(ca[0]), 32'h100);
    check("R11 latency lift", 32'(lat), 32'd1);
    check("R5 lifted done_cur", 32'(d_cur), 32'h120);
  endtask

  task automatic t_fold();
    set_ring(1'b1, 3, 'h40, 'h100, 'h130);
    run_req(1'b1, 3, 'h10, 1'b0, 0);
    check("R4 fold addr", 32'(ca[0]), 32'h70);
    check("R4 fold len", 32'(cl[0]), 32'h10);
    check("R11 latency fold", 32'(lat), 32'(AW + 2));
    check("R4 fold done_cur", 32'(d_cur), 32'h80);
    wr(1'b1, 3, 2, 'h100);
    run_req(1'b1, 3, 'h10, 1'b0, 0);
    check("R4 cur at end folds", 32'(ca[0]), 32'h40);
    check("R4 cur at end done", 32'(d_cur), 32'h50);
    set_ring(1'b1, 3, 'h100, 'h180, 'h1a0);
    run_req(1'b1, 3, 'h8, 1'b0, 0);
    check("R5 fold then lift", 32'(ca[0]), 32'h100);
    check("R5 fold then lift done", 32'(d_cur), 32'h108);
  endtask

  task automatic t_invalid();
    logic [AW-1:0] v;
    set_ring(1'b1, 1, 'h300, 'h300, 'h2f0);
    run_req(1'b1, 1, 'h10, 1'b0, 0);
    check("R3 empty ring err", 32'(d_err), 32'd1);
    check("R3 empty ring no chunk", 32'(n_chk), 32'd0);
    rd(1'b1, 1, 2, v); check("R3 empty ring cur kept", 32'(v), 32'h2f0);
    run_req(1'b1, 4, 'h10, 1'b0, 0);
    check("R3 absent out index err", 32'(d_err), 32'd1);
    check("R3 absent out index no chunk", 32'(n_chk), 32'd0);
    run_req(1'b0, 2, 'h10, 1'b0, 0);
    check("R3 absent in index err", 32'(d_err), 32'd1);
  endtask

  task automatic t_zero_len();
    logic [AW-1:0] v;
    set_ring(1'b0, 0, 'h100, 'h200, 'h20);
    run_req(1'b0, 0, 0, 1'b0, 0);
    check("R9 zero length no chunk", 32'(n_chk), 32'd0);
    check("R9 zero length err", 32'(d_err), 32'd0);
    check("R9 zero length done_cur", 32'(d_cur), 32'h100);
    rd(1'b0, 0, 2, v); check("R9 zero length write-back", 32'(v), 32'h100);
  endtask

  task automatic t_sink();
    set_ring(1'b1, 0, 'h0, 'h100, 'h0);
    run_req(1'b1, 0, 'h10, 1'b1, 0);
    check("R10 out0 silence", 32'(cz[0]), 32'd1);
    check("R10 out0 dir", 32'(cd[0]), 32'd1);
    run_req(1'b1, 0, 'h10, 1'b0, 0);
    check("R10 out0 no silence", 32'(cz[0]), 32'd0);
    set_ring(1'b0, 0, 'h0, 'h100, 'h0);
    run_req(1'b0, 0, 'h10, 1'b1, 0);
    check("R10 in0 silence ignored", 32'(cz[0]), 32'd0);
    check("R10 in0 dir", 32'(cd[0]), 32'd0);
  endtask

  task automatic t_stall();
    set_ring(1'b0, 1, 'h200, 'h280, 'h260);
    run_req(1'b0, 1, 'h40, 1'b0, 3);
    check("R8 held steady", 32'(stab_bad), 32'd0);
    check("R8 stall count", 32'(n_chk), 32'd2);
    check("R8 stall c0", {ca[0], cl[0]}, {16'h260, 16'h20});
    check("R8 stall c1", {ca[1], cl[1]}, {16'h200, 16'h20});
    check("R8 stall done_cur", 32'(d_cur), 32'h220);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regmap();
    t_single();
    t_wrap();
    t_multi();
    t_lift();
    t_fold();
    t_invalid();
    t_zero_len();
    t_sink();
    t_stall();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule